// File: doc/BRIEF.md
# Parallel Memory Reprogramming Sequencer

This block sits on the host side of an asynchronous parallel rewriteable memory that has a command-write interface but no way to report when an operation has finished. On a start pulse it rewrites the whole memory from a stream of words. The sequence has four stages. First it enters the identification mode and reads the two code words at offsets 0 and 1, then leaves that mode. If both codes match, it issues the erase command and waits a fixed number of clocks. It then takes words from a valid/ready source and writes each one with an unlock-and-program command, followed by a fixed wait. Word n of the stream goes to memory address n.

The memory gives no status polling, so every erase and program is timed by a clock count that is a parameter. The memory can only clear bits when it programs a word, so the whole array is always erased before the first word is written. The setup, strobe-low and hold lengths of every bus cycle are parameters in clocks. An optional verify mode reads each word back after its program wait.

The state machine has these states:
- `S_IDLE`: waits for `start`.
- `S_ID_ENTER`: writes the three identification-entry commands.
- `S_ID_READ`: reads offsets 0 and 1.
- `S_ID_EXIT`: writes the exit command and compares the codes.
- `S_ERASE_CMD`: writes the six erase commands.
- `S_ERASE_WAIT`: runs the erase timer.
- `S_FETCH`: waits for a source word.
- `S_PROG_CMD`: writes three commands and then the word.
- `S_PROG_WAIT`: runs the program timer.
- `S_VERIFY`: reads the word back.
- `S_FINISH`: sets `done`, then returns to `S_IDLE`.

The transitions are:
- `S_IDLE` to `S_ID_ENTER` on `start`.
- `S_ID_ENTER` to `S_ID_READ` after the third write.
- `S_ID_READ` to `S_ID_EXIT` after the second read.
- `S_ID_EXIT` to `S_FINISH` if a code is wrong, otherwise to `S_ERASE_CMD`.
- `S_ERASE_CMD` to `S_ERASE_WAIT` after the sixth write.
- `S_ERASE_WAIT` to `S_FINISH` when the word count is zero, otherwise to `S_FETCH`.
- `S_FETCH` to `S_PROG_CMD` on a handshake.
- `S_PROG_CMD` to `S_PROG_WAIT` after the fourth write.
- `S_PROG_WAIT` to `S_VERIFY` when verify is on. With verify off it goes to `S_FETCH`, or to `S_FINISH` after the last word.
- `S_VERIFY` to `S_FINISH` on a mismatch or after the last word, otherwise to `S_FETCH`.

Top module: `flash_reprog_seq`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe` is low, and `busy`, `done` and `error` are low.
- R2: After `start`, the first bus writes are data AAh at 5555h, 55h at 2AAAh and 90h at 5555h. Two reads follow, at address 0000h and at 0001h. Then F0h is written at 0000h. Command data has its upper byte at zero.
- R3: If the word read at 0000h is not 001Eh, or the word read at 0001h is not 0051h, the sequencer sets `error` and finishes after the F0h write. It issues no erase and no program.
- R4: With valid codes, the next six writes are AAh at 5555h, 55h at 2AAAh, 80h at 5555h, AAh at 5555h, 55h at 2AAAh and 10h at 5555h.
- R5: After the final erase write, the chip enable stays high for at least `ERASE_WAIT` clocks.
- R6: Each source word is accepted with `src_valid` and `src_ready` both high. The k-th accepted word (k from 0) is written as AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then the word itself at address k. `src_ready` is high only while the bus is idle.
- R7: After each word write, the chip enable stays high for at least `PROG_WAIT` clocks.
- R8: In every write, `mem_we_n` is low for exactly `PULSE_CYC` clocks. Throughout that time `mem_oe_n` is high, `mem_ce_n` is low, the data is driven, and the address and data are stable.
- R9: With `VERIFY_EN` set, each word is read back after its wait. On a difference the sequencer sets `error`, puts the word's address on `fail_addr`, and finishes without taking further words.
- R10: With a word count of zero, the sequencer finishes after the erase wait and makes no program writes.
- R11: A `start` pulse while `busy` is high is ignored. `word_count` is sampled only when the job starts.
- R12: `done` rises in the same cycle that `busy` falls. `done`, `error` and `fail_addr` hold their values until the next accepted `start`, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle job request |
| word_count | input | ADDR_W+1 | Number of words to program |
| src_valid | input | 1 | Source word is valid |
| src_ready | output | 1 | Sequencer accepts a source word |
| src_data | input | DATA_W | Source word |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | DATA_W | Data driven to memory |
| mem_dq_oe | output | 1 | Enable for the data driver |
| mem_dq_in | input | DATA_W | Data read from memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| busy | output | 1 | A job is running |
| done | output | 1 | The last job has finished |
| error | output | 1 | The last job failed on the codes or on verify |
| fail_addr | output | ADDR_W | Address of the first verify mismatch |

## Verification
The bench keeps a model of the memory and goes after four corner cases.
- Wrong identification code: a design that ignored it would erase the array and wipe the words programmed in an earlier job.
- Word count of zero: a design that got it wrong would program a stray word or hang in the fetch state.
- Stuck bit at one address under verify: a design that mishandled it would keep programming later words or report the wrong address.
- Second `start` during a job, with a different count: a design that accepted it would restart identification or cut the job short.

The bench also stalls the source, which catches writes issued with no word. It checks each gap after an erase or program against the wait, which catches waits that are too short.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ID_ENTER,
        S_ID_READ,
        S_ID_EXIT,
        S_ERASE_CMD,
        S_ERASE_WAIT,
        S_FETCH,
        S_PROG_CMD,
        S_PROG_WAIT,
        S_VERIFY,
        S_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD
    } bus_phase_t;

    localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
    localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  UNLOCK_BYTE_A = 8'hAA;
    localparam logic [7:0]  UNLOCK_BYTE_B = 8'h55;
    localparam logic [7:0]  OP_ID_ENTER   = 8'h90;
    localparam logic [7:0]  OP_ID_LEAVE   = 8'hF0;
    localparam logic [7:0]  OP_ERASE_ARM  = 8'h80;
    localparam logic [7:0]  OP_ERASE_ALL  = 8'h10;
    localparam logic [7:0]  OP_PROGRAM    = 8'hA0;

    // Address of step idx within a three-write unlock group.
    function automatic logic [15:0] cmd_addr(input logic [2:0] idx);
        return (idx == 3'd1) ? UNLOCK_ADDR_B : UNLOCK_ADDR_A;
    endfunction

    // Data byte of step idx. The third step carries the operation code.
    function automatic logic [7:0] cmd_byte(input logic [2:0] idx, input logic [7:0] op);
        if (idx == 3'd0)      return UNLOCK_BYTE_A;
        else if (idx == 3'd1) return UNLOCK_BYTE_B;
        else                  return op;
    endfunction

endpackage

// File: rtl/flash_bus_strobe.sv
module flash_bus_strobe
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);
    localparam int MAX_SP = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_C  = (MAX_SP > HOLD_CYC) ? MAX_SP : HOLD_CYC;
    localparam int CW     = $clog2(MAX_C + 1);

    bus_phase_t        phase;
    logic [CW-1:0]     cnt;
    logic              rd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            rd_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            ack     <= 1'b0;
            rdata   <= '0;
        end else begin
            ack <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (req && !ack) begin
                        rd_q    <= rd;
                        addr_q  <= addr;
                        wdata_q <= wdata;
                        cnt     <= CW'(SETUP_CYC - 1);
                        phase   <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        cnt   <= CW'(PULSE_CYC - 1);
                        phase <= PH_PULSE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_PULSE: begin
                    if (cnt == '0) begin
                        if (rd_q) rdata <= mem_dq_in;
                        cnt   <= CW'(HOLD_CYC - 1);
                        phase <= PH_HOLD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) begin
                        ack   <= 1'b1;
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_addr   = addr_q;
        mem_dq_out = wdata_q;
        mem_ce_n   = (phase == PH_IDLE);
        mem_we_n   = !((phase == PH_PULSE) && !rd_q);
        mem_oe_n   = !((phase == PH_PULSE) && rd_q);
        mem_dq_oe  = (phase != PH_IDLE) && !rd_q;
    end
endmodule

// File: rtl/flash_wait_timer.sv
module flash_wait_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] len,
    output logic          fire
);
    logic [TW-1:0] cnt;
    logic          running;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
            fire    <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (start) begin
                cnt     <= len - 1'b1;
                running <= 1'b1;
            end else if (running) begin
                if (cnt == '0) begin
                    running <= 1'b0;
                    fire    <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/flash_reprog_seq.sv
module flash_reprog_seq
    import flash_seq_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 16,
    parameter int          SETUP_CYC  = 2,
    parameter int          PULSE_CYC  = 3,
    parameter int          HOLD_CYC   = 1,
    parameter int          ERASE_WAIT = 25_000_000,
    parameter int          PROG_WAIT  = 1_000,
    parameter bit          VERIFY_EN  = 1'b1,
    parameter logic [15:0] ID_MFR     = 16'h001E,
    parameter logic [15:0] ID_DEV     = 16'h0051
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W:0]   word_count,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [ADDR_W-1:0] fail_addr
);
    localparam int TW = $clog2(ERASE_WAIT + 1);
    localparam int CW = ADDR_W + 1;

    seq_state_t        state, state_nx;
    logic [2:0]        step, idx;
    logic [CW-1:0]     cnt_q, word_idx;
    logic [DATA_W-1:0] data_q, id0_q, id1_q;
    logic              bus_req, bus_rd, bus_ack;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata, bus_rdata;
    logic              tmr_start, tmr_fire;
    logic [TW-1:0]     tmr_len;
    logic              id_bad, vfy_bad, last_word;

    assign id_bad    = (id0_q != DATA_W'(ID_MFR)) || (id1_q != DATA_W'(ID_DEV));
    assign vfy_bad   = (bus_rdata != data_q);
    assign last_word = ((word_idx + CW'(1)) == cnt_q);
    assign idx       = (step >= 3'd3) ? (step - 3'd3) : step;
    assign busy      = (state != S_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:       if (start) state_nx = S_ID_ENTER;
            S_ID_ENTER:   if (bus_ack && step == 3'd2) state_nx = S_ID_READ;
            S_ID_READ:    if (bus_ack && step == 3'd1) state_nx = S_ID_EXIT;
            S_ID_EXIT:    if (bus_ack) state_nx = id_bad ? S_FINISH : S_ERASE_CMD;
            S_ERASE_CMD:  if (bus_ack && step == 3'd5) state_nx = S_ERASE_WAIT;
            S_ERASE_WAIT: if (tmr_fire) state_nx = (cnt_q == '0) ? S_FINISH : S_FETCH;
            S_FETCH:      if (src_valid) state_nx = S_PROG_CMD;
            S_PROG_CMD:   if (bus_ack && step == 3'd3) state_nx = S_PROG_WAIT;
            S_PROG_WAIT:  if (tmr_fire) state_nx = VERIFY_EN ? S_VERIFY
                                                   : (last_word ? S_FINISH : S_FETCH);
            S_VERIFY:     if (bus_ack) state_nx = (vfy_bad || last_word) ? S_FINISH : S_FETCH;
            S_FINISH:     state_nx = S_IDLE;
            default:      state_nx = S_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        bus_req   = 1'b0;
        bus_rd    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        src_ready = 1'b0;
        tmr_start = 1'b0;
        tmr_len   = TW'(PROG_WAIT);
        unique case (state)
            S_ID_ENTER: begin
                bus_req   = 1'b1;
                bus_addr  = ADDR_W'(cmd_addr(idx));
                bus_wdata = DATA_W'(cmd_byte(idx, OP_ID_ENTER));
            end
            S_ID_READ: begin
                bus_req  = 1'b1;
                bus_rd   = 1'b1;
                bus_addr = ADDR_W'(step);
            end
            S_ID_EXIT: begin
                bus_req   = 1'b1;
                bus_wdata = DATA_W'(OP_ID_LEAVE);
            end
            S_ERASE_CMD: begin
                bus_req   = 1'b1;
                bus_addr  = ADDR_W'(cmd_addr(idx));
                bus_wdata = DATA_W'(cmd_byte(idx, (step < 3'd3) ? OP_ERASE_ARM : OP_ERASE_ALL));
                tmr_start = bus_ack && (step == 3'd5);
                tmr_len   = TW'(ERASE_WAIT);
            end
            S_FETCH: src_ready = 1'b1;
            S_PROG_CMD: begin
                bus_req = 1'b1;
                if (step == 3'd3) begin
                    bus_addr  = word_idx[ADDR_W-1:0];
                    bus_wdata = data_q;
                end else begin
                    bus_addr  = ADDR_W'(cmd_addr(idx));
                    bus_wdata = DATA_W'(cmd_byte(idx, OP_PROGRAM));
                end
                tmr_start = bus_ack && (step == 3'd3);
            end
            S_VERIFY: begin
                bus_req  = 1'b1;
                bus_rd   = 1'b1;
                bus_addr = word_idx[ADDR_W-1:0];
            end
            S_IDLE, S_ERASE_WAIT, S_PROG_WAIT, S_FINISH: ;
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step      <= '0;
            cnt_q     <= '0;
            word_idx  <= '0;
            data_q    <= '0;
            id0_q     <= '0;
            id1_q     <= '0;
            done      <= 1'b0;
            error     <= 1'b0;
            fail_addr <= '0;
        end else begin
            if (state_nx != state) step <= '0;
            else if (bus_ack)      step <= step + 3'd1;

            if (state == S_IDLE && start) begin
                cnt_q     <= word_count;
                word_idx  <= '0;
                done      <= 1'b0;
                error     <= 1'b0;
                fail_addr <= '0;
            end
            if (state == S_ID_READ && bus_ack) begin
                if (step == 3'd0) id0_q <= bus_rdata;
                else              id1_q <= bus_rdata;
            end
            if (state == S_ID_EXIT && bus_ack && id_bad) error <= 1'b1;
            if (state == S_FETCH && src_valid) data_q <= src_data;
            if (state == S_VERIFY && bus_ack && vfy_bad) begin
                error     <= 1'b1;
                fail_addr <= word_idx[ADDR_W-1:0];
            end
            if ((state == S_PROG_WAIT || state == S_VERIFY) && state_nx == S_FETCH)
                word_idx <= word_idx + CW'(1);
            if (state == S_FINISH) done <= 1'b1;
        end
    end

    flash_bus_strobe #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
    ) u_bus (
        .clk(clk), .rst_n(rst_n),
        .req(bus_req), .rd(bus_rd), .addr(bus_addr), .wdata(bus_wdata),
        .ack(bus_ack), .rdata(bus_rdata),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n)
    );

    flash_wait_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .len(tmr_len), .fire(tmr_fire)
    );
endmodule

// File: rtl/flash_reprog_seq_chk.sv
module flash_reprog_seq_chk #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int PULSE_CYC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              error,
    input logic              src_ready,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_out
);
    localparam int LW = $clog2(PULSE_CYC + 2);
    logic [LW-1:0] lo_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)        lo_cnt <= '0;
        else if (mem_we_n) lo_cnt <= '0;
        else               lo_cnt <= lo_cnt + 1'b1;
    end

    AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (lo_cnt == LW'(PULSE_CYC))); // R8
    AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_dq_oe)); // R8
    AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R8
    AST_READY_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> (mem_ce_n && busy)); // R6
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R12
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R12
    AST_ERROR_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !busy) |-> done); // R3
endmodule

bind flash_reprog_seq flash_reprog_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .error(error),
    .src_ready(src_ready), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out)
);

// File: tb/flash_reprog_seq_tb.sv
module flash_reprog_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int PULSE = 3;
    localparam int EWAIT = 200;
    localparam int PWAIT = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW:0]   word_count = '0;
    logic          src_valid = 1'b0;
    logic          src_ready;
    logic [DW-1:0] src_data = '0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic          mem_dq_oe;
    logic [DW-1:0] mem_dq_in = '0;
    logic          mem_ce_n, mem_oe_n, mem_we_n;
    logic          busy, done, error;
    logic [AW-1:0] fail_addr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_reprog_seq #(
        .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(2), .PULSE_CYC(PULSE), .HOLD_CYC(1),
        .ERASE_WAIT(EWAIT), .PROG_WAIT(PWAIT), .VERIFY_EN(1'b1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .word_count(word_count),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .busy(busy), .done(done), .error(error),
        .fail_addr(fail_addr)
    );

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    // Scoreboard of expected writes: {addr, data}, with requirement tag
    logic [31:0] exp_q[$];
    string       tag_q[$];

    // Memory model
    logic [DW-1:0] mem_model [int];
    bit            id_mode = 0, prog_armed = 0;
    bit            bad_id = 0, stuck_en = 0;
    int            stuck_addr = 0;
    int            gap_kind = 0, gap_mark = 0, lo_cnt = 0;
    logic          prev_we = 1'b1, prev_ce = 1'b1;
    logic [DW-1:0] words[8];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input int act, input int lim);
        n_checks++;
        if (act < lim) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
        end
    endtask

    function automatic logic [DW-1:0] stored(input int a);
        return mem_model.exists(a) ? mem_model[a] : 16'hFFFF;
    endfunction

    function automatic logic [DW-1:0] model_read(input int a);
        if (id_mode) begin
            if (a == 0) return 16'h001E;
            if (a == 1) return bad_id ? 16'h0052 : 16'h0051;
            return 16'h0000;
        end
        return (stuck_en && a == stuck_addr) ? (stored(a) | 16'h0001) : stored(a);
    endfunction

    // Monitor: bus model and scoreboard compare
    always @(negedge clk) begin
        if (!mem_ce_n && !mem_oe_n) mem_dq_in = model_read(int'(mem_addr));
        else                        mem_dq_in = '0;
        if (prev_ce && !mem_ce_n) begin
            if (gap_kind == 1)      chk_ge("R5 erase wait", cyc - gap_mark, EWAIT);
            else if (gap_kind == 2) chk_ge("R7 program wait", cyc - gap_mark, PWAIT);
            gap_kind = 0;
        end
        if (!mem_we_n) lo_cnt++;
        if (!prev_we && mem_we_n) begin
            int a;
            logic [DW-1:0] d;
            a = int'(mem_addr);
            d = mem_dq_out;
            chk("R8 strobe width", lo_cnt, PULSE);
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fails++;
                $display("FAIL R6 unexpected write actual=%h expected=none", {mem_addr, d});
            end else begin
                string t;
                logic [31:0] e;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, {mem_addr, d}, e);
            end
            if (prog_armed) begin
                mem_model[a] = stored(a) & d;
                prog_armed = 0;
                gap_kind = 2;
                gap_mark = cyc;
            end else if (a == 'h5555 && d[7:0] == 8'hA0) prog_armed = 1;
            else if (a == 'h5555 && d[7:0] == 8'h90) id_mode = 1;
            else if (d[7:0] == 8'hF0) id_mode = 0;
            else if (a == 'h5555 && d[7:0] == 8'h10) begin
                mem_model.delete();
                gap_kind = 1;
                gap_mark = cyc;
            end
            lo_cnt = 0;
        end
        prev_we = mem_we_n;
        prev_ce = mem_ce_n;
    end

    // Driver tasks: push expected writes
    task automatic push(input string t, input logic [15:0] a, input logic [15:0] d);
        exp_q.push_back({a, d});
        tag_q.push_back(t);
    endtask

    task automatic expect_id();
        push("R2 id enter", 16'h5555, 16'h00AA);
        push("R2 id enter", 16'h2AAA, 16'h0055);
        push("R2 id enter", 16'h5555, 16'h0090);
        push("R2 id exit",  16'h0000, 16'h00F0);
    endtask

    task automatic expect_erase();
        push("R4 erase", 16'h5555, 16'h00AA);
        push("R4 erase", 16'h2AAA, 16'h0055);
        push("R4 erase", 16'h5555, 16'h0080);
        push("R4 erase", 16'h5555, 16'h00AA);
        push("R4 erase", 16'h2AAA, 16'h0055);
        push("R4 erase", 16'h5555, 16'h0010);
    endtask

    task automatic expect_word(input int k, input logic [15:0] d);
        push("R6 program", 16'h5555, 16'h00AA);
        push("R6 program", 16'h2AAA, 16'h0055);
        push("R6 program", 16'h5555, 16'h00A0);
        push("R6 program", 16'(k), d);
    endtask

    task automatic launch(input int n);
        @(negedge clk);
        word_count = (AW + 1)'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic feed(input int n, input int stall_at);
        for (int i = 0; i < n; i++) begin
            if (i == stall_at) begin
                src_valid = 1'b0;
                repeat (7) @(negedge clk);
            end
            src_valid = 1'b1;
            src_data  = words[i];
            while (!src_ready) @(negedge clk);
            @(negedge clk);
            src_valid = 1'b0;
        end
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 bus idle", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
        chk("R1 flags", {busy, done, error}, 3'b000);

        // Job A: five words, a stalled source and a stray start
        words[0] = 16'h1234; words[1] = 16'hA5A5; words[2] = 16'h0F0F;
        words[3] = 16'h8001; words[4] = 16'h7FFE;
        expect_id();
        expect_erase();
        for (int i = 0; i < 5; i++) expect_word(i, words[i]);
        launch(5);
        chk("R12 done cleared on start", done, 1'b0);
        fork
            feed(5, 2);
            begin
                repeat (30) @(negedge clk);
                word_count = 1; // R11 stray start with a different count
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        wait_done();
        chk("R9 verify pass error", error, 1'b0);
        chk("R6 all writes seen", exp_q.size(), 0);
        for (int i = 0; i < 5; i++) chk("R6 stored word", stored(i), words[i]);
        repeat (5) @(negedge clk);
        chk("R12 done held", {done, busy}, 2'b10);

        // Job B: wrong device code
        bad_id = 1;
        expect_id();
        launch(3);
        wait_done();
        chk("R3 error on bad id", error, 1'b1);
        chk("R3 no erase or program", exp_q.size(), 0);
        chk("R3 array untouched", stored(0), 16'h1234);
        bad_id = 0;

        // Job C: zero words
        expect_id();
        expect_erase();
        launch(0);
        wait_done();
        chk("R10 zero-count error", error, 1'b0);
        chk("R10 no program writes", exp_q.size(), 0);
        chk("R4 array erased", stored(0), 16'hFFFF);

        // Job D: stuck bit at address 2 under verify
        stuck_en = 1; stuck_addr = 2;
        words[0] = 16'h1110; words[1] = 16'h2220; words[2] = 16'h3330;
        expect_id();
        expect_erase();
        for (int i = 0; i < 3; i++) expect_word(i, words[i]);
        launch(5);
        feed(3, 8);
        wait_done();
        chk("R9 verify error", error, 1'b1);
        chk("R9 fail address", fail_addr, 16'h0002);
        repeat (40) @(negedge clk);
        chk("R9 stopped after mismatch", exp_q.size(), 0);
        chk("R12 error held", {done, error}, 2'b11);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule